// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns a fast system clock into the timing enables an I2C master needs. A single baud byte programs two cascaded dividers. The first stage divides by a power of two. The second stage divides by a linear factor. Together they produce a one-cycle `tick` enable. The bus engine gets ten ticks per SCL period, so it can place its SDA and SCL edges at fixed tenths of a bit.

A phase counter steps through ten SCL phases, one per tick. For the first half of the period the block reports the clock line low, and for the second half it reports it high. The resulting SCL frequency is Fclk / (10 × (M+1) × 2^(N+1)). A build-time parameter selects a variant whose exponential stage divides by 2^N instead of 2^(N+1).

Writing the baud byte restarts all counters. The new rate therefore begins with a whole period and never with a truncated one.

Top module: `scl_rate_gen`

## Requirements
- R1: The baud byte carries the linear field M in bits 6:3 and the exponent field N in bits 2:0. Bit 7 is ignored on write. `baud_q` returns the stored fields, with bit 7 always 0.
- R2: After synchronous active-low reset, `baud_q` reads 0x44 (M=8, N=4), `scl_phase` is 0, `scl_level` is 0 and `tick` is 0.
- R3: In the default build, consecutive `tick` pulses are exactly D = (M+1)·2^(N+1) clock cycles apart, for every M in 0..15 and N in 0..7.
- R4: `tick` is a single-cycle enable. In the default build it is never high on two consecutive cycles.
- R5: `scl_phase` counts 0..9. It advances by one on each tick, wraps from 9 to 0, and holds on every cycle without a tick.
- R6: `scl_level` is 0 while `scl_phase` is 0..4 and 1 while it is 5..9. It therefore rises only on entering phase 5 and falls only on entering phase 0.
- R7: A write with `baud_wr` high clears both divider stages and the phase counter at that clock edge. The first tick at the new rate comes exactly D cycles after the write edge, where the negedge following the write edge counts as cycle 1.
- R8: With EXP_SHIFT=0 the divisor is D = (M+1)·2^N. Baud 0x00 then gives a tick on every cycle.
- R9: Asserting reset in mid-operation restores the state of R2. The first tick after reset follows the reset-value divisor of 288 cycles, counted the same way as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_wr | input | 1 | Write strobe for the baud byte |
| baud_wdata | input | 8 | New baud byte: M in bits 6:3, N in bits 2:0 |
| baud_q | output | 8 | Stored baud byte, with bit 7 reading 0 |
| tick | output | 1 | One-cycle enable, ten per SCL period |
| scl_phase | output | 4 | Current SCL phase, 0..9 |
| scl_level | output | 1 | Intended SCL level: low for phases 0..4, high for 5..9 |

## Verification
The bench builds two instances side by side. The first uses the default EXP_SHIFT=1 and the 0x44 reset value. The second uses EXP_SHIFT=0, which brings the divide-by-one corner within reach: there `tick` stays high on every cycle and the phase advances every clock. The default instance is driven through both ends of the field ranges, from the smallest divisor of 2 up to the largest of 4096, and through a byte with bit 7 set. A rewrite in mid-period and a reset in mid-run show that the count restarts cleanly.

// File: rtl/scl_div_pkg.sv
// Package: shared constants and the baud field layout for the SCL divider.
// Assumes an 8-bit baud byte whose top bit is unused.
package scl_div_pkg;
    localparam int BAUD_W     = 8;
    localparam int LIN_W      = 4;
    localparam int EXP_W      = 3;
    localparam int SCL_PHASES = 10;
    localparam int PHASE_W    = $clog2(SCL_PHASES);
    localparam int HIGH_FROM  = SCL_PHASES / 2;

    // Field order matters: linear factor sits above the exponent.
    typedef struct packed {
        logic [LIN_W-1:0] lin;
        logic [EXP_W-1:0] expo;
    } baud_fields_t;
endpackage

// File: rtl/scl_baud_reg.sv
// Module: holds the baud fields and flags a restart on every write.
// Assumes writes are single-cycle strobes; the unused top bit is dropped.
module scl_baud_reg
    import scl_div_pkg::*;
#(
    parameter logic [BAUD_W-1:0] RESET_BAUD = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BAUD_W-1:0] wdata,
    output baud_fields_t      fields,
    output logic [BAUD_W-1:0] readback,
    output logic              restart
);
    localparam int FIELD_W = LIN_W + EXP_W;

    // Store the programmed fields; reset loads the default rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields <= baud_fields_t'(RESET_BAUD[FIELD_W-1:0]);
        end else if (wr) begin
            fields <= baud_fields_t'(wdata[FIELD_W-1:0]);
        end
    end

    // Present the stored byte with the unused upper bits zero.
    assign readback = {{(BAUD_W-FIELD_W){1'b0}}, fields};
    assign restart  = wr;
endmodule

// File: rtl/scl_pow2_stage.sv
// Module: first divider stage, a free-running counter wrapping every
// 2^(expo+EXP_SHIFT) cycles. Assumes expo is stable between restarts.
module scl_pow2_stage #(
    parameter int N_W       = 3,
    parameter int EXP_SHIFT = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [N_W-1:0] expo,
    output logic           term
);
    localparam int MAX_EXP = (1 << N_W) - 1 + EXP_SHIFT;
    localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [N_W:0]     eff_exp;

    // Pick the exponent offset of the selected variant.
    generate
        if (EXP_SHIFT != 0) begin : g_shifted
            assign eff_exp = {1'b0, expo} + (N_W+1)'(EXP_SHIFT);
        end else begin : g_plain
            assign eff_exp = {1'b0, expo};
        end
    endgenerate

    // Terminal count: eff_exp low bits set, i.e. 2^eff_exp - 1.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(eff_exp));
        end
    end

    assign term = (cnt == limit);

    // Count up, wrap at the terminal value, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_linear_stage.sv
// Module: second divider stage, counts 0..lin on each first-stage wrap
// and emits one pulse per full cycle. Assumes step is a one-cycle enable.
module scl_linear_stage #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic [M_W-1:0] lin,
    output logic           wrap
);
    logic [M_W-1:0] cnt;

    assign wrap = step && (cnt == lin);

    // Advance on each step, wrap after lin, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_seq.sv
// Module: steps the SCL phase once per tick and derives the line level.
// Assumes the phase count is even, so low and high halves are equal.
module scl_phase_seq
    import scl_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               adv,
    output logic [PHASE_W-1:0] phase,
    output logic               level
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SCL_PHASES - 1);
    localparam logic [PHASE_W-1:0] HIGH = PHASE_W'(HIGH_FROM);

    // Move to the next phase on a tick; wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= '0;
        end else if (adv) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign level = (phase >= HIGH);
endmodule

// File: rtl/scl_rate_gen.sv
// Module: top of the SCL rate divider. A power-of-two stage feeds a
// linear stage whose wrap is the tick; the phase sequencer follows.
// Assumes one clock domain; tick is an enable, not a clock.
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter int                EXP_SHIFT  = 1,
    parameter logic [BAUD_W-1:0] RESET_BAUD = 8'h44
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               baud_wr,
    input  logic [BAUD_W-1:0]  baud_wdata,
    output logic [BAUD_W-1:0]  baud_q,
    output logic               tick,
    output logic [PHASE_W-1:0] scl_phase,
    output logic               scl_level
);
    baud_fields_t fields;
    logic         restart;
    logic         pre_term;

    scl_baud_reg #(.RESET_BAUD(RESET_BAUD)) u_baud (
        .clk(clk), .rst_n(rst_n), .wr(baud_wr), .wdata(baud_wdata),
        .fields(fields), .readback(baud_q), .restart(restart)
    );

    scl_pow2_stage #(.N_W(EXP_W), .EXP_SHIFT(EXP_SHIFT)) u_pow2 (
        .clk(clk), .rst_n(rst_n), .clear(restart),
        .expo(fields.expo), .term(pre_term)
    );

    scl_linear_stage #(.M_W(LIN_W)) u_lin (
        .clk(clk), .rst_n(rst_n), .clear(restart), .step(pre_term),
        .lin(fields.lin), .wrap(tick)
    );

    scl_phase_seq u_phase (
        .clk(clk), .rst_n(rst_n), .clear(restart), .adv(tick),
        .phase(scl_phase), .level(scl_level)
    );
endmodule

// File: rtl/scl_rate_gen_chk.sv
// Module: property checker for scl_rate_gen, attached by bind.
// Observes ports only.
module scl_rate_gen_chk
    import scl_div_pkg::*;
#(
    parameter int                EXP_SHIFT  = 1,
    parameter logic [BAUD_W-1:0] RESET_BAUD = 8'h44
) (
    input logic               clk,
    input logic               rst_n,
    input logic               baud_wr,
    input logic [BAUD_W-1:0]  baud_wdata,
    input logic [BAUD_W-1:0]  baud_q,
    input logic               tick,
    input logic [PHASE_W-1:0] scl_phase,
    input logic               scl_level
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SCL_PHASES - 1);

    assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        baud_q[BAUD_W-1] == 1'b0);

    assert_reset_state_R2: assert property (@(posedge clk)
        !rst_n |=> (baud_q == {1'b0, RESET_BAUD[BAUD_W-2:0]} && scl_phase == '0));

    generate
        if (EXP_SHIFT != 0) begin : g_single
            assert_single_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_phase <= LAST);

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !baud_wr) |=> $stable(scl_phase));

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !baud_wr && scl_phase != LAST) |=> scl_phase == $past(scl_phase) + 1'b1);

    assert_phase_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !baud_wr && scl_phase == LAST) |=> scl_phase == '0);

    assert_level_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_level) |-> scl_phase == PHASE_W'(HIGH_FROM));

    assert_level_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_level) |-> scl_phase == '0);

    assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        baud_wr |=> (scl_phase == '0 && baud_q[BAUD_W-2:0] == $past(baud_wdata[BAUD_W-2:0])));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.EXP_SHIFT(EXP_SHIFT), .RESET_BAUD(RESET_BAUD)) u_chk (.*);

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    // {baud written, expected readback, expected divisor D}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_00_0002, 32'h01_01_0004, 32'h08_08_0004,
        32'h44_44_0120, 32'h7F_7F_1000, 32'h3A_3A_0040,
        32'h95_15_00C0, 32'h27_27_0500, 32'h78_78_0020
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_a = 1'b0, wr_b = 1'b0;
    logic [7:0] wd_a = '0, wd_b = '0;
    logic [7:0] q_a, q_b;
    logic tick_a, tick_b, lvl_a, lvl_b;
    logic [3:0] ph_a, ph_b;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_rate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .baud_wr(wr_a), .baud_wdata(wd_a),
        .baud_q(q_a), .tick(tick_a), .scl_phase(ph_a), .scl_level(lvl_a)
    );

    scl_rate_gen #(.EXP_SHIFT(0)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .baud_wr(wr_b), .baud_wdata(wd_b),
        .baud_q(q_b), .tick(tick_b), .scl_phase(ph_b), .scl_level(lvl_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic tk(input bit sel);
        return sel ? tick_b : tick_a;
    endfunction

    // Write at a posedge; returns at the following negedge (cycle 1).
    task automatic wr_baud(input bit sel, input logic [7:0] v);
        @(negedge clk);
        if (sel) begin wr_b = 1'b1; wd_b = v; end
        else     begin wr_a = 1'b1; wd_a = v; end
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    // Cycles until the first tick, counting the current negedge as 1.
    task automatic first_tick(input bit sel, output int n);
        n = 1;
        while (!tk(sel) && n < 10000) begin @(negedge clk); n++; end
    endtask

    // Cycles from the current tick to the next one.
    task automatic next_gap(input bit sel, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tk(sel) && n < 10000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 baud", q_a, 8'h44);
        chk("R2 phase", ph_a, 0);
        chk("R2 level", lvl_a, 0);
        chk("R2 tick", tick_a, 0);
        rst_n = 1'b1;
        first_tick(0, n);
        chk("R9 first tick after reset", n, 288);

        // R1 R3 R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            wr_baud(0, VEC[i][31:24]);
            chk("R1 readback", q_a, VEC[i][23:16]);
            chk("R7 phase cleared", ph_a, 0);
            first_tick(0, n);
            chk("R7 first tick", n, VEC[i][15:0]);
            next_gap(0, n);
            chk("R3 tick gap", n, VEC[i][15:0]);
        end

        // R5 R6 R4: phase walk at D=2
        wr_baud(0, 8'h00);
        first_tick(0, n);
        for (int k = 0; k < 10; k++) begin
            chk("R5 phase", ph_a, k);
            chk("R6 level", lvl_a, (k >= 5) ? 1 : 0);
            @(negedge clk);
            chk("R4 no double tick", tick_a, 0);
            chk("R5 phase holds", ph_a, (k + 1) % 10);
            @(negedge clk);
        end
        chk("R5 wrap", ph_a, 0);

        // R7: rewrite in mid-period
        wr_baud(0, 8'h44);
        repeat (100) @(negedge clk);
        wr_baud(0, 8'h08);
        chk("R7 mid rewrite phase", ph_a, 0);
        first_tick(0, n);
        chk("R7 mid rewrite first tick", n, 4);

        // R8: variant without exponent offset
        wr_baud(1, 8'h00);
        chk("R8 tick at cycle 1", tick_b, 1);
        chk("R8 phase", ph_b, 0);
        @(negedge clk);
        chk("R8 tick every cycle", tick_b, 1);
        chk("R8 phase steps", ph_b, 1);
        wr_baud(1, 8'h44);
        first_tick(1, n);
        chk("R8 first tick", n, 144);
        next_gap(1, n);
        chk("R8 gap", n, 144);

        // R9: reset in mid-run
        wr_baud(0, 8'h01);
        repeat (13) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 baud", q_a, 8'h44);
        chk("R9 phase", ph_a, 0);
        first_tick(0, n);
        chk("R9 tick after mid reset", n, 288);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule